// File: doc/BRIEF.md
# Speaker Control and Status Port

This block is a byte-wide I/O register that drives a speaker tone path and reports its state. A CPU write to the port sets two control flags: the gate of an on-chip tone timer and a speaker-data enable. A CPU read returns both flags together with the live timer output level and a refresh indicator that flips on every read. Software that polls the refresh bit sees it alternate, which is how it paces short delay loops.

The tone timer is a small down-counter. It reloads from a 16-bit divisor input and produces a square wave. It runs only while the gate is set, and its output idles high while the gate is clear. The speaker pin is the timer output qualified by the data enable. The I/O side is a plain strobe bus: an address, a write strobe with write data and a read strobe. Read data comes back registered one cycle later, marked by a one-cycle valid pulse. Every access completes in one cycle, so there is no back-pressure: the block has no ready signal and never stalls the bus.

Top module: `spk_ctrl_port`

## Requirements
- R1: Only accesses whose full address equals the port address (default 0x0061) take effect. A write to any other address changes no state. A read to any other address leaves io_rvalid low and does not flip the refresh bit.
- R2: A port write loads write-data bit 0 into the timer gate and write-data bit 1 into the speaker-data enable. Write-data bits 7 to 2 have no effect.
- R3: A port read returns its byte on io_rdata in the cycle after the read strobe, with io_rvalid high for exactly that cycle. Bit 0 holds the gate, bit 1 the data enable, bit 4 the refresh indicator and bit 5 the timer output. Bits 7, 6, 3 and 2 read 0.
- R4: The refresh indicator inverts on every port read, and the read returns the inverted value. The first read after reset therefore returns 1 in bit 4.
- R5: While the gate is 1, the timer output toggles once every H clocks, where H is the divisor shifted right by one, or 1 when that is 0. The first toggle comes H clocks after the write that sets the gate.
- R6: spk_out is high only while both the timer output and the data enable are 1. With the enable at 0 it stays low whatever the timer does.
- R7: Reset clears the gate, the data enable, the refresh bit, io_rdata and io_rvalid, and sets the timer output high. spk_out is therefore low after reset.
- R8: When a port read and a port write fall in the same cycle, the read returns the flag values from before that write, and the write still takes effect.
- R9: When the gate is cleared, the timer output is high by the second clock after the write and stays high while the gate remains 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| io_rvalid | output | 1 | High for the cycle in which io_rdata carries a port read |
| divisor | input | 16 | Timer reload value; the half period is this value shifted right by one |
| spk_out | output | 1 | Speaker drive: timer output AND data enable |

## Verification
A read and a write to the port can fall in the same cycle. The read must then report the old flags while the write updates them. The bench raises both strobes together on one clock with write data that differs from the stored flags. It checks that the returned byte carries the old gate and enable with the refresh bit advanced, and that a later read shows the new flags. The timer toggling in the same cycle as a read is also exercised: reads are issued while the gate is running, and bit 5 is compared with the output level at that moment.

// File: rtl/spk_pkg.sv
package spk_pkg;
  localparam int DATA_W  = 8;
  // read/write bit positions of the port byte
  localparam int BIT_GATE = 0;
  localparam int BIT_EN   = 1;
  localparam int BIT_REF  = 4;
  localparam int BIT_OUT  = 5;
endpackage

// File: rtl/spk_tone_timer.sv
module spk_tone_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic [DIV_W-1:0] divisor,
  output logic             tone
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] half_w;
  logic [DIV_W-1:0] reload_w;
  logic [DIV_W-1:0] cnt_q;
  logic             out_q;

  assign half_w   = divisor >> 1;
  assign reload_w = (half_w == '0) ? ONE : half_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ONE;
      out_q <= 1'b1;
    end else if (!gate) begin
      cnt_q <= reload_w;
      out_q <= 1'b1;
    end else if (cnt_q <= ONE) begin
      cnt_q <= reload_w;
      out_q <= ~out_q;
    end else begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign tone = out_q;

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> tone); // R9
  AST_HOLD_MID_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && cnt_q > ONE) |=> (tone == $past(tone))); // R5
  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    gate |=> (cnt_q != '0)); // R5
endmodule

// File: rtl/spk_port_regs.sv
module spk_port_regs
  import spk_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0061
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              tone,
  output logic              gate,
  output logic              data_en,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rvalid
);
  logic              hit_w, rd_hit, wr_hit;
  logic              gate_q, en_q, ref_q, rvalid_q;
  logic [DATA_W-1:0] rdata_q, rd_word;

  assign hit_w  = (io_addr == PORT_ADDR);
  assign rd_hit = io_rd && hit_w;
  assign wr_hit = io_wr && hit_w;

  always_comb begin
    rd_word           = '0;
    rd_word[BIT_GATE] = gate_q;
    rd_word[BIT_EN]   = en_q;
    rd_word[BIT_REF]  = ~ref_q;
    rd_word[BIT_OUT]  = tone;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q   <= 1'b0;
      en_q     <= 1'b0;
      ref_q    <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_hit;
      if (rd_hit) begin
        ref_q   <= ~ref_q;
        rdata_q <= rd_word;
      end
      if (wr_hit) begin
        gate_q <= io_wdata[BIT_GATE];
        en_q   <= io_wdata[BIT_EN];
      end
    end
  end

  assign gate      = gate_q;
  assign data_en   = en_q;
  assign io_rdata  = rdata_q;
  assign io_rvalid = rvalid_q;

  AST_RVALID_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> $past(io_rd && io_addr == PORT_ADDR)); // R1
  AST_REFRESH_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (ref_q != $past(ref_q))); // R4
  AST_REFRESH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> $stable(ref_q)); // R1
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> (io_rdata[7:6] == 2'b00 && io_rdata[3:2] == 2'b00)); // R3
  AST_FLAGS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(gate) && $stable(data_en))); // R2
endmodule

// File: rtl/spk_ctrl_port.sv
module spk_ctrl_port
  import spk_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DIV_W     = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0061
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rvalid,
  input  logic [DIV_W-1:0]  divisor,
  output logic              spk_out
);
  logic gate_w, en_w, tone_w;

  spk_port_regs #(
    .ADDR_W   (ADDR_W),
    .PORT_ADDR(PORT_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .tone     (tone_w),
    .gate     (gate_w),
    .data_en  (en_w),
    .io_rdata (io_rdata),
    .io_rvalid(io_rvalid)
  );

  spk_tone_timer #(
    .DIV_W(DIV_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate   (gate_w),
    .divisor(divisor),
    .tone   (tone_w)
  );

  assign spk_out = tone_w & en_w;

  AST_SPK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (spk_out && io_rvalid) |-> io_rdata[BIT_EN] || $past(io_wr)); // R6
endmodule

// File: tb/spk_ctrl_port_bench.sv
module spk_ctrl_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rvalid;
  logic [15:0] divisor = 16'd1000;
  logic        spk_out;

  int tests = 0;
  int fails = 0;
  logic ref_m = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  spk_ctrl_port u_spk_ctrl_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .divisor(divisor), .spk_out(spk_out)
  );

  // {addr, wdata, expected gate, expected enable}
  localparam logic [25:0] TBL [8] = '{
    {16'h0061, 8'h00, 1'b0, 1'b0},
    {16'h0061, 8'h01, 1'b1, 1'b0},
    {16'h0061, 8'h02, 1'b0, 1'b1},
    {16'h0061, 8'h03, 1'b1, 1'b1},
    {16'h0060, 8'h00, 1'b1, 1'b1},
    {16'h0061, 8'hFC, 1'b0, 1'b0},
    {16'h00E1, 8'h03, 1'b0, 1'b0},
    {16'h0061, 8'h02, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata; v = io_rvalid;
  endtask

  task automatic port_rd(output logic [7:0] d);
    logic v;
    rd(16'h0061, d, v);
    ref_m = ~ref_m;
    chk("R3 rvalid", {15'd0, v}, 16'd1);
  endtask

  task automatic settle;
    repeat (3) @(negedge clk);
  endtask

  // clocks from the setting write until spk_out changes level
  task automatic measure(input logic lvl, output int k);
    k = 0;
    while (spk_out === lvl && k < 5000) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       v;
    int         k;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 rdata", {8'd0, io_rdata}, 16'd0);
    chk("R7 rvalid", {15'd0, io_rvalid}, 16'd0);
    chk("R7 spk_out", {15'd0, spk_out}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    port_rd(d);
    chk("R7 R4 first read", {8'd0, d}, 16'h0030);

    // table walk: R1 R2 R3 R4 R6
    for (int i = 0; i < 8; i++) begin
      logic [15:0] a;
      logic [7:0]  w;
      logic        g, e;
      {a, w, g, e} = TBL[i];
      wr(a, w);
      port_rd(d);
      chk("R2 R3 table read", {8'd0, d}, {8'd0, 2'b00, 1'b1, ref_m, 2'b00, e, g});
      chk("R6 table spk", {15'd0, spk_out}, {15'd0, e});
    end

    // R1 foreign read: no rvalid, no refresh flip
    rd(16'h0161, d, v);
    chk("R1 foreign rvalid", {15'd0, v}, 16'd0);
    port_rd(d);
    chk("R1 R4 refresh after foreign read", {15'd0, d[4]}, {15'd0, ref_m});

    // R5 timer period across divisors
    for (int j = 0; j < 4; j++) begin
      int h;
      case (j)
        0: divisor = 16'd10;
        1: divisor = 16'd7;
        2: divisor = 16'd1;
        default: divisor = 16'd0;
      endcase
      h = (divisor >> 1) == 0 ? 1 : int'(divisor >> 1);
      wr(16'h0061, 8'h02);
      settle();
      wr(16'h0061, 8'h03);
      measure(1'b1, k);
      chk("R5 first half period", 16'(k), 16'(h));
      measure(1'b0, k);
      chk("R5 second half period", 16'(k), 16'(h));
    end

    // R5 timer output seen through bit 5 while running
    divisor = 16'd40;
    wr(16'h0061, 8'h02);
    settle();
    wr(16'h0061, 8'h03);
    repeat (25) @(negedge clk);
    port_rd(d);
    chk("R5 bit5 low mid wave", {15'd0, d[5]}, 16'd0);

    // R9 gate cleared: output high by second clock
    wr(16'h0061, 8'h02);
    @(negedge clk);
    chk("R9 idle high", {15'd0, spk_out}, 16'd1);
    repeat (30) @(negedge clk);
    chk("R9 stays high", {15'd0, spk_out}, 16'd1);

    // R6 enable low silences running timer
    divisor = 16'd4;
    wr(16'h0061, 8'h01);
    k = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (spk_out) k++;
    end
    chk("R6 muted", 16'(k), 16'd0);

    // R8 simultaneous read and write
    wr(16'h0061, 8'h02);
    settle();
    @(negedge clk);
    io_addr = 16'h0061; io_wdata = 8'h01; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    ref_m = ~ref_m;
    chk("R8 old flags", {8'd0, io_rdata}, {8'd0, 2'b00, 1'b1, ref_m, 4'b0010});
    port_rd(d);
    chk("R8 new flags", {14'd0, d[1:0]}, 16'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule